// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block collects every interrupt condition of a 16550-style serial port register file and turns them into two results: an 8-bit identification value that names the most urgent enabled source, and one interrupt request line for the host. The shift registers, FIFOs and baud generator are not part of it. It receives their status: receive FIFO fill level, push and read strobes, baud ticks, transmit holding-empty, line-error events and modem-line delta events. It also receives the host's register access strobes, and each source is cleared by its own access.

A receive character-timeout detector is built in. It counts baud ticks while the receive FIFO holds data and nothing enters or leaves it. While the host is reading the identification register, the reported value is held steady. Any change that happens during the access appears once the access ends. A transmit-empty interrupt is cleared when that access reported it.

All inputs and outputs are plain control and status pins. There is no data stream and no handshake.

Top module: `uart_irq_ident`

## Requirements
- R1: The identification value `iir` has bits 7 and 6 both equal to `fifo_en` and bits 5 and 4 always 0. Bit 0 is 0 when an enabled interrupt is pending and 1 when none is, so an idle block reads 0x01 with FIFOs off and 0xC1 with FIFOs on. `irq` is high exactly when bit 0 would be 0.
- R2: Bits 3..1 give the code of the top enabled pending source. The codes are line status 011, receive data 010, character timeout 110, transmit empty 001 and modem status 000. Priority runs line status > receive data > character timeout > transmit empty > modem status. Bit 3 is forced to 0 when `fifo_en` is 0.
- R3: The enable mask `ier` gates sources as follows: bit 0 gates receive data and timeout, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem status. A disabled source neither drives `irq` nor appears in `iir`.
- R4: Receive data is pending as a level. With `fifo_en`=0 it is pending when `rx_level` is nonzero. With `fifo_en`=1 it is pending when `rx_level` is at or above the trigger chosen by `rx_trig_sel` (00:1, 01:4, 10:8, 11:14).
- R5: With `fifo_en`=1 and `rx_level` nonzero, a character timeout becomes pending after 4×`char_ticks` `baud_tick` pulses with no `rx_push` and no `rbr_rd`. Any push or read restarts the count. The timeout flag clears on `rbr_rd`, on an empty FIFO, or when FIFOs are off, and it never fires with FIFOs off.
- R6: Any bit of `ls_err_evt` makes line status pending one cycle later. `lsr_rd` clears it, and a new event in the same cycle as the read wins.
- R7: Transmit empty becomes pending on a rising edge of `thr_empty`, and `thr_wr` clears it.
- R8: At the end of an identification read (`iir_acc` falling), transmit empty is cleared only if the value reported during that access showed the transmit-empty code.
- R9: Any bit of `ms_delta_evt` makes modem status pending. `msr_rd` clears it.
- R10: While `iir_acc` is held, `iir` keeps the value it showed in the first cycle of the access. New conditions appear in the cycle after the access ends.
- R11: After reset no source is pending, `irq` is 0 and `iir` reads 0x01 with FIFOs off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_trig_sel | input | 2 | Receive trigger level select |
| ier | input | 4 | Interrupt enable mask |
| char_ticks | input | CT_W | Baud ticks per character time |
| baud_tick | input | 1 | Baud tick pulse |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_push | input | 1 | Character entered the receive FIFO |
| rbr_rd | input | 1 | Host read of the receive buffer |
| ls_err_evt | input | 4 | Overrun, parity, framing, break events |
| lsr_rd | input | 1 | Host read of line status |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Host write of the transmit buffer |
| ms_delta_evt | input | 4 | Modem line change events |
| msr_rd | input | 1 | Host read of modem status |
| iir_acc | input | 1 | Identification register read in progress |
| iir | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
A table of source combinations is applied, each starting from a cleared state. Single sources check the code map. Stacked sources check that the higher level hides the lower ones. Enable masks check the gating, and fill levels on either side of each trigger check FIFO-mode detection. Directed sequences then cover the cases the table cannot. A read that starts before a new error arrives separates a held value from a live one. A read that reported line status must leave transmit empty pending, while one that reported transmit empty must clear it. Steady ticks with and without periodic pushes separate the timeout firing from the timeout restarting.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;

  typedef enum logic [2:0] {
    SRC_LS  = 3'd0,
    SRC_RXD = 3'd1,
    SRC_TO  = 3'd2,
    SRC_TX  = 3'd3,
    SRC_MS  = 3'd4
  } irq_src_e;

  function automatic logic [2:0] src_code(input int idx);
    case (idx)
      0:       return 3'b011;
      1:       return 3'b010;
      2:       return 3'b110;
      3:       return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/irq_sticky.sv
module irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/irq_tx_empty.sv
module irq_tx_empty (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic thr_wr,
  input  logic rd_clr,
  output logic pend_o
);
  logic empty_q;
  logic rise;

  assign rise = thr_empty & ~empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      empty_q <= thr_empty;
      if (rise)                 pend_o <= 1'b1;
      else if (thr_wr | rd_clr) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int CT_W  = 12,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [CT_W-1:0]  char_ticks,
  input  logic             baud_tick,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rbr_rd,
  output logic             to_pend
);
  localparam int CW = CT_W + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          empty;
  logic          restart;
  logic          hit;

  assign limit   = {char_ticks, 2'b00};
  assign empty   = (rx_level == '0);
  assign restart = rx_push | rbr_rd | empty | ~fifo_en;
  assign hit     = baud_tick & (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (restart)                    cnt <= '0;
    else if (baud_tick && cnt != limit)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          to_pend <= 1'b0;
    else if (rbr_rd | empty | ~fifo_en)  to_pend <= 1'b0;
    else if (!restart && hit)            to_pend <= 1'b1;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  output logic [2:0]      code,
  output logic            any
);
  always_comb begin
    code = 3'b000;
    any  = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        code = src_code(i);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CT_W       = 12,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [1:0]       rx_trig_sel,
  input  logic [3:0]       ier,
  input  logic [CT_W-1:0]  char_ticks,
  input  logic             baud_tick,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic [3:0]       ls_err_evt,
  input  logic             lsr_rd,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic [3:0]       ms_delta_evt,
  input  logic             msr_rd,
  input  logic             iir_acc,
  output logic [7:0]       iir,
  output logic             irq
);
  localparam int NSTK = 2;

  // sticky sources: index 0 line status, index 1 modem status
  logic [NSTK-1:0] stk_set, stk_clr, stk_pend;
  assign stk_set = {|ms_delta_evt, |ls_err_evt};
  assign stk_clr = {msr_rd, lsr_rd};

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    irq_sticky u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stk_set[g]),
      .clr_i (stk_clr[g]),
      .pend_o(stk_pend[g])
    );
  end

  logic to_pend;
  irq_rx_timeout #(.CT_W(CT_W), .LVL_W(LVL_W)) u_to (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .char_ticks(char_ticks),
    .baud_tick (baud_tick),
    .rx_level  (rx_level),
    .rx_push   (rx_push),
    .rbr_rd    (rbr_rd),
    .to_pend   (to_pend)
  );

  logic       held;
  logic [7:0] snap;
  logic       acc_end;
  logic       tx_rd_clr;
  logic       tx_pend;

  assign acc_end   = held & ~iir_acc;
  assign tx_rd_clr = acc_end & (snap[3:0] == {src_code(SRC_TX), 1'b0});

  irq_tx_empty u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_empty(thr_empty),
    .thr_wr   (thr_wr),
    .rd_clr   (tx_rd_clr),
    .pend_o   (tx_pend)
  );

  // receive data available as a level
  logic [LVL_W:0] trig;
  logic           rxd_avail;
  assign trig      = (LVL_W + 1)'(trig_level(rx_trig_sel));
  assign rxd_avail = fifo_en ? ({1'b0, rx_level} >= trig) : (rx_level != '0);

  logic [NSRC-1:0] req;
  always_comb begin
    req          = '0;
    req[SRC_LS]  = stk_pend[0] & ier[2];
    req[SRC_RXD] = rxd_avail   & ier[0];
    req[SRC_TO]  = to_pend     & ier[0] & fifo_en;
    req[SRC_TX]  = tx_pend     & ier[1];
    req[SRC_MS]  = stk_pend[1] & ier[3];
  end

  logic [2:0] code;
  logic       any;
  irq_prio_enc u_enc (
    .req (req),
    .code(code),
    .any (any)
  );

  logic [7:0] live;
  assign live = {fifo_en, fifo_en, 2'b00, code[2] & fifo_en, code[1:0], ~any};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      snap <= 8'h01;
    end else begin
      held <= iir_acc;
      if (iir_acc && !held) snap <= live;
    end
  end

  assign iir = held ? snap : live;
  assign irq = |req;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic [3:0] ier,
  input logic [3:0] ls_err_evt,
  input logic       lsr_rd,
  input logic [3:0] ms_delta_evt,
  input logic       msr_rd,
  input logic       iir_acc,
  input logic [7:0] iir,
  input logic       irq
);
  // R1
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iir_acc |-> (iir[5:4] == 2'b00 && iir[7:6] == {fifo_en, fifo_en}));

  // R1
  pend_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iir_acc |-> (iir[0] == !irq));

  // R2
  no_fifo_bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iir_acc && !fifo_en) |-> !iir[3]);

  // R3
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ier != 4'b0000));

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_acc && $past(iir_acc)) |=> (iir_acc ? 1'b1 : 1'b1) && $stable(iir) || !$past(iir_acc, 1));

  // R6
  ls_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && ls_err_evt == 4'h0 && !iir_acc) |=>
      (iir_acc || !(iir[3:1] == 3'b011 && !iir[0])));

  // R9
  ms_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && ms_delta_evt == 4'h0 && !iir_acc) |=>
      (iir_acc || !(iir[3:1] == 3'b000 && !iir[0])));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_en     (fifo_en),
  .ier         (ier),
  .ls_err_evt  (ls_err_evt),
  .lsr_rd      (lsr_rd),
  .ms_delta_evt(ms_delta_evt),
  .msr_rd      (msr_rd),
  .iir_acc     (iir_acc),
  .iir         (iir),
  .irq         (irq)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam int CT_W  = 12;
  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fifo_en = 1'b0;
  logic [1:0]       rx_trig_sel = 2'd0;
  logic [3:0]       ier = 4'h0;
  logic [CT_W-1:0]  char_ticks = 12'd2;
  logic             baud_tick = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic             rx_push = 1'b0;
  logic             rbr_rd = 1'b0;
  logic [3:0]       ls_err_evt = 4'h0;
  logic             lsr_rd = 1'b0;
  logic             thr_empty = 1'b0;
  logic             thr_wr = 1'b0;
  logic [3:0]       ms_delta_evt = 4'h0;
  logic             msr_rd = 1'b0;
  logic             iir_acc = 1'b0;
  logic [7:0]       iir;
  logic             irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_irq_ident uut (.*);

  // fields: fen ier ls ms tx lvl trig exp_iir exp_irq
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 4'hF, 1'b1, 1'b0, 1'b0, 5'd0,  2'd0, 8'h06, 1'b1},
    {1'b0, 4'hF, 1'b1, 1'b1, 1'b1, 5'd1,  2'd0, 8'h06, 1'b1},
    {1'b0, 4'hF, 1'b0, 1'b1, 1'b1, 5'd1,  2'd0, 8'h04, 1'b1},
    {1'b0, 4'hF, 1'b0, 1'b1, 1'b1, 5'd0,  2'd0, 8'h02, 1'b1},
    {1'b0, 4'hF, 1'b0, 1'b1, 1'b0, 5'd0,  2'd0, 8'h00, 1'b1},
    {1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 5'd1,  2'd0, 8'h01, 1'b0},
    {1'b0, 4'h8, 1'b1, 1'b1, 1'b1, 5'd1,  2'd0, 8'h00, 1'b1},
    {1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 5'd3,  2'd1, 8'hC1, 1'b0},
    {1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 5'd4,  2'd1, 8'hC4, 1'b1},
    {1'b1, 4'hF, 1'b0, 1'b0, 1'b1, 5'd13, 2'd3, 8'hC2, 1'b1},
    {1'b1, 4'hF, 1'b0, 1'b0, 1'b0, 5'd1,  2'd0, 8'hC4, 1'b1},
    {1'b1, 4'h2, 1'b1, 1'b0, 1'b1, 5'd0,  2'd0, 8'hC2, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    rx_level = '0; thr_empty = 1'b0; baud_tick = 1'b0;
    lsr_rd = 1'b1; msr_rd = 1'b1; thr_wr = 1'b1;
    cyc(1);
    lsr_rd = 1'b0; msr_rd = 1'b0; thr_wr = 1'b0;
    cyc(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    // R11 reset state
    chk("R11 iir in reset", iir, 8'h01);
    chk("R11 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc(2);
    chk("R11 iir after reset", iir, 8'h01);

    // table: R1 R2 R3 R4 across source mixes
    for (int v = 0; v < NV; v++) begin
      clear_all();
      fifo_en     = VEC[v][23];
      ier         = VEC[v][22:19];
      rx_level    = VEC[v][15:11];
      rx_trig_sel = VEC[v][10:9];
      thr_empty   = VEC[v][16];
      ls_err_evt  = VEC[v][18] ? 4'h2 : 4'h0;
      ms_delta_evt= VEC[v][17] ? 4'h8 : 4'h0;
      cyc(1);
      ls_err_evt = 4'h0; ms_delta_evt = 4'h0;
      cyc(1);
      chk($sformatf("R2 R3 R4 vec%0d iir", v), iir, VEC[v][8:1]);
      chk($sformatf("R1 vec%0d irq", v), {7'd0, irq}, {7'd0, VEC[v][0]});
    end

    // R10 freeze during access
    fifo_en = 1'b0; ier = 4'hF; clear_all();
    ms_delta_evt = 4'h1; cyc(1); ms_delta_evt = 4'h0; cyc(1);
    chk("R9 modem pending", iir, 8'h00);
    iir_acc = 1'b1; cyc(1);
    ls_err_evt = 4'h1; cyc(1); ls_err_evt = 4'h0; cyc(1);
    chk("R10 held during access", iir, 8'h00);
    chk("R10 irq live during access", {7'd0, irq}, 8'h01);
    iir_acc = 1'b0; cyc(1);
    chk("R10 shown after access", iir, 8'h06);
    // R6 clear and set-wins
    lsr_rd = 1'b1; ls_err_evt = 4'h4; cyc(1);
    lsr_rd = 1'b0; ls_err_evt = 4'h0; cyc(1);
    chk("R6 event wins over read", iir, 8'h06);
    lsr_rd = 1'b1; cyc(1); lsr_rd = 1'b0; cyc(1);
    chk("R6 cleared by read", iir, 8'h00);
    msr_rd = 1'b1; cyc(1); msr_rd = 1'b0; cyc(1);
    chk("R9 cleared by read", iir, 8'h01);

    // R8 transmit empty cleared by reporting read
    clear_all();
    thr_empty = 1'b1; cyc(2);
    chk("R7 set on rise", iir, 8'h02);
    iir_acc = 1'b1; cyc(1); iir_acc = 1'b0; cyc(1);
    chk("R8 cleared by reporting read", iir, 8'h01);
    // R8 not cleared when line status was reported
    clear_all();
    thr_empty = 1'b1; ls_err_evt = 4'h8; cyc(1); ls_err_evt = 4'h0; cyc(1);
    iir_acc = 1'b1; cyc(2); iir_acc = 1'b0; cyc(1);
    lsr_rd = 1'b1; cyc(1); lsr_rd = 1'b0; cyc(1);
    chk("R8 kept when not reported", iir, 8'h02);
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0; cyc(1);
    chk("R7 cleared by write", iir, 8'h01);
    cyc(3);
    chk("R7 level high no re-set", iir, 8'h01);

    // R5 character timeout
    clear_all();
    fifo_en = 1'b1; rx_trig_sel = 2'd3; rx_level = 5'd2;
    rx_push = 1'b1; cyc(1); rx_push = 1'b0;
    baud_tick = 1'b1; cyc(4);
    chk("R5 not yet", iir, 8'hC1);
    cyc(8);
    chk("R5 timeout fired", iir, 8'hCC);
    rbr_rd = 1'b1; cyc(1); rbr_rd = 1'b0;
    chk("R5 cleared by read", iir, 8'hC1);
    for (int k = 0; k < 6; k++) begin
      cyc(5); rx_push = 1'b1; cyc(1); rx_push = 1'b0;
    end
    chk("R5 restart by push", iir, 8'hC1);
    fifo_en = 1'b0; cyc(20);
    chk("R5 none without FIFO", iir, 8'h04);
    baud_tick = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule